// File: doc/BRIEF.md
# Two-Channel Compare-Match Interval Timer

This block is a periodic tick source for a processor subsystem. It holds a small bank of 16-bit registers on a simple bus (address, write enable, write data and a combinational read data return). Each of its channels owns an up-counter that advances on a prescaled version of the block clock. When the counter reaches the channel's compare value, the counter wraps to zero and a sticky match flag is set. If the channel's interrupt enable is set, the channel's interrupt line is raised and stays high until software clears the flag.

Software programs a compare value and a prescaler choice, then sets the channel's bit in a shared run-control register. It reads the counter to work out how much of the current interval has passed. Channels run and stop independently. A stopped channel keeps its count and restarts its divider from the beginning.

Top module: `cmt_timer`

## Requirements
- R1: After reset, every register reads 0x0000, except the two compare registers, which read 0xFFFF.
- R2: The run-control register at offset 0x0 holds one run bit per channel (bit 0 for channel 0, bit 1 for channel 1). Its other bits read 0. Writing one channel's bit has no effect on the other channel.
- R3: While running, a channel's counter advances once every 8, 32, 128 or 512 clock cycles, chosen by control bits [1:0] = 0, 1, 2 or 3. The first advance comes one full divide period after the clock edge that sets the run bit.
- R4: On the advance where the counter equals the compare value, the counter becomes 0 and control bit 7 (match flag) becomes 1 on that same clock edge.
- R5: Writing 1 to bit 7 leaves the flag unchanged, and writing 0 to it clears the flag. If a match and a write of 0 land on the same edge, the flag ends up set.
- R6: A channel's interrupt output is high exactly while its match flag and its control bit 6 (interrupt enable) are both 1.
- R7: While a channel is stopped, its counter holds its value. On restart, the first advance again needs a full divide period.
- R8: A write to the counter or compare register takes effect on the next edge, whether the channel is running or stopped. A counter write on an advance edge replaces the advance.
- R9: Channel 0 has its control/status register at 0x2, counter at 0x4 and compare at 0x6. Channel 1 has them at 0x8, 0xA and 0xC. Control bits other than 7, 6 and [1:0] read 0. Each write reaches at most one register.
- R10: Reads from unmapped addresses (including odd addresses and 0xE) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 4 | Register byte address |
| we | input | 1 | Write strobe for the addressed register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register, combinational |
| irq | output | 2 | Per-channel interrupt request |

## Verification
The bench builds the block with its default parameters: two channels, 16-bit registers, a base divide of 8 and a factor of 4 between selections. With these values, every prescaler choice up to /512 can be reached, and so can the exact edge where a match coincides with a software flag clear or with a counter load. Short compare values keep several full match periods within a few hundred cycles. A full /512 period on channel 1 is also walked, to check the widest tap and the channel 1 address map.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  // Register map (byte offsets)
  localparam int OFS_RUN    = 0;
  localparam int CH_BASE    = 2;
  localparam int CH_STRIDE  = 6;
  localparam int OFS_CTL    = 0;
  localparam int OFS_COUNT  = 2;
  localparam int OFS_LIMIT  = 4;

  // Control/status bit positions
  localparam int FLAG_BIT   = 7;
  localparam int IE_BIT     = 6;

  typedef enum logic [1:0] {
    DIV_8   = 2'd0,
    DIV_32  = 2'd1,
    DIV_128 = 2'd2,
    DIV_512 = 2'd3
  } div_sel_e;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 3,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int PRE_W = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] tap_mask;

  // Low bits that must all be ones for the selected divide ratio
  always_comb begin
    tap_mask = ({{(PRE_W-1){1'b0}}, 1'b1} << (BASE_LOG2 + STEP_LOG2 * int'(sel))) - 1'b1;
  end

  always_comb begin
    pre_d = run ? pre_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = run && ((pre_q & tap_mask) == tap_mask);

  // Smallest ratio is 2**BASE_LOG2 > 1, so ticks never come back to back
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // A stopped divider restarts from zero
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int DW        = 16,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 3,
  parameter int STEP_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ctl_we,
  input  logic          count_we,
  input  logic          limit_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_rd,
  output logic [DW-1:0] count_rd,
  output logic [DW-1:0] limit_rd,
  output logic          irq
);
  logic [DW-1:0]    count_q, count_d;
  logic [DW-1:0]    limit_q, limit_d;
  logic             flag_q, flag_d;
  logic             ie_q, ie_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             tick;
  logic             hit;

  cmt_prescaler #(
    .SEL_W    (SEL_W),
    .BASE_LOG2(BASE_LOG2),
    .STEP_LOG2(STEP_LOG2)
  ) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (sel_q),
    .tick (tick)
  );

  assign hit = tick && (count_q == limit_q);

  // Next-state logic
  always_comb begin
    count_d = count_q;
    if (count_we)  count_d = wdata;
    else if (hit)  count_d = '0;
    else if (tick) count_d = count_q + 1'b1;

    limit_d = limit_we ? wdata : limit_q;

    flag_d = flag_q;
    if (hit)                           flag_d = 1'b1;
    else if (ctl_we && !wdata[FLAG_BIT]) flag_d = 1'b0;

    ie_d  = ctl_we ? wdata[IE_BIT]    : ie_q;
    sel_d = ctl_we ? wdata[SEL_W-1:0] : sel_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      limit_q <= '1;
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      sel_q   <= '0;
    end else begin
      count_q <= count_d;
      limit_q <= limit_d;
      flag_q  <= flag_d;
      ie_q    <= ie_d;
      sel_q   <= sel_d;
    end
  end

  always_comb begin
    ctl_rd              = '0;
    ctl_rd[FLAG_BIT]    = flag_q;
    ctl_rd[IE_BIT]      = ie_q;
    ctl_rd[SEL_W-1:0]   = sel_q;
  end

  assign count_rd = count_q;
  assign limit_rd = limit_q;
  assign irq      = flag_q && ie_q;

  assert_hold_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !count_we) |=> $stable(count_q));
  assert_wrap_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !count_we) |=> (count_q == '0) && flag_q);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(ctl_we && !wdata[FLAG_BIT])) |=> flag_q);
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctl_we) |=> flag_q);
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int DW        = 16,
  parameter int AW        = 4,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 3,
  parameter int STEP_LOG2 = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           we,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] irq
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Run-control register
  logic           run_we;
  logic [NCH-1:0] run_q, run_d;

  assign run_we = we && (addr == AW'(OFS_RUN));

  always_comb begin
    run_d = run_we ? wdata[NCH-1:0] : run_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) run_q <= '0;
    else            run_q <= run_d;
  end

  // Channels
  logic [NCH-1:0] ctl_we, count_we, limit_we;
  logic [DW-1:0]  ctl_rd   [NCH];
  logic [DW-1:0]  count_rd [NCH];
  logic [DW-1:0]  limit_rd [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * i;

    assign ctl_we[i]   = we && (addr == AW'(BASE + OFS_CTL));
    assign count_we[i] = we && (addr == AW'(BASE + OFS_COUNT));
    assign limit_we[i] = we && (addr == AW'(BASE + OFS_LIMIT));

    cmt_channel #(
      .DW       (DW),
      .SEL_W    (SEL_W),
      .BASE_LOG2(BASE_LOG2),
      .STEP_LOG2(STEP_LOG2)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .run     (run_q[i]),
      .ctl_we  (ctl_we[i]),
      .count_we(count_we[i]),
      .limit_we(limit_we[i]),
      .wdata   (wdata),
      .ctl_rd  (ctl_rd[i]),
      .count_rd(count_rd[i]),
      .limit_rd(limit_rd[i]),
      .irq     (irq[i])
    );

    assert_irq_tracks_ctl_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
      irq[i] == (ctl_rd[i][FLAG_BIT] && ctl_rd[i][IE_BIT]));
  end

  // Read return
  always_comb begin
    rdata = '0;
    if (addr == AW'(OFS_RUN)) rdata = DW'(run_q);
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(CH_BASE + CH_STRIDE * i + OFS_CTL))   rdata = ctl_rd[i];
      if (addr == AW'(CH_BASE + CH_STRIDE * i + OFS_COUNT)) rdata = count_rd[i];
      if (addr == AW'(CH_BASE + CH_STRIDE * i + OFS_LIMIT)) rdata = limit_rd[i];
    end
  end

  assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({run_we, ctl_we, count_we, limit_we}));
endmodule

// File: tb/tb_cmt_timer.sv
module tb_cmt_timer;
  logic        clk;
  logic        rst_n;
  logic [3:0]  addr;
  logic        we;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cmt_timer dut (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (addr),
    .we   (we),
    .wdata(wdata),
    .rdata(rdata),
    .irq  (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  // op: 0 write, 1 read and compare, 2 idle data cycles
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  a;
    logic [15:0] d;
    logic [15:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 4'h0, 16'h0000, 16'h0000, 8'd1},  // R1
    '{2'd1, 4'h2, 16'h0000, 16'h0000, 8'd1},  // R1
    '{2'd1, 4'h4, 16'h0000, 16'h0000, 8'd1},  // R1
    '{2'd1, 4'h6, 16'h0000, 16'hFFFF, 8'd1},  // R1
    '{2'd1, 4'h8, 16'h0000, 16'h0000, 8'd1},  // R1
    '{2'd1, 4'hA, 16'h0000, 16'h0000, 8'd1},  // R1
    '{2'd1, 4'hC, 16'h0000, 16'hFFFF, 8'd1},  // R1
    '{2'd1, 4'hE, 16'h0000, 16'h0000, 8'd10}, // R10
    '{2'd1, 4'h3, 16'h0000, 16'h0000, 8'd10}, // R10
    '{2'd0, 4'h2, 16'hFFFF, 16'h0000, 8'd9},
    '{2'd1, 4'h2, 16'h0000, 16'h0043, 8'd9},  // R9, R5
    '{2'd0, 4'h0, 16'hFFFC, 16'h0000, 8'd2},
    '{2'd1, 4'h0, 16'h0000, 16'h0000, 8'd2},  // R2
    '{2'd0, 4'h4, 16'h1234, 16'h0000, 8'd8},
    '{2'd1, 4'h4, 16'h0000, 16'h1234, 8'd8},  // R8
    '{2'd0, 4'hA, 16'h00AB, 16'h0000, 8'd8},
    '{2'd1, 4'hA, 16'h0000, 16'h00AB, 8'd9},  // R9
    '{2'd1, 4'h4, 16'h0000, 16'h1234, 8'd9},  // R9
    '{2'd0, 4'hC, 16'h7777, 16'h0000, 8'd8},
    '{2'd1, 4'hC, 16'h0000, 16'h7777, 8'd8},  // R8
    '{2'd1, 4'h6, 16'h0000, 16'hFFFF, 8'd9},  // R9
    '{2'd2, 4'h0, 16'd40,   16'h0000, 8'd7},
    '{2'd1, 4'h4, 16'h0000, 16'h1234, 8'd7},  // R7
    '{2'd0, 4'h2, 16'h0000, 16'h0000, 8'd9},
    '{2'd1, 4'h2, 16'h0000, 16'h0000, 8'd9},  // R9
    '{2'd0, 4'h8, 16'h0042, 16'h0000, 8'd9},
    '{2'd1, 4'h8, 16'h0000, 16'h0042, 8'd9}   // R9
  };

  task automatic tick_wait(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    we    = 1'b1;
    @(posedge clk);
    #1;
    we    = 1'b0;
  endtask

  task automatic expect_val(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    addr = a;
    #1;
    expect_val(rdata, exp, tag);
  endtask

  task automatic do_reset();
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick_wait(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    do_reset();
    expect_val(16'(irq), 16'h0, "R1 irq after reset");

    // Vector table: register access with channels stopped
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].a, VEC[i].d);
        2'd1: rd(VEC[i].a, VEC[i].e, $sformatf("R%0d vector %0d", VEC[i].req, i));
        default: tick_wait(int'(VEC[i].d));
      endcase
    end

    // R3, R4, R6: /8 counting and match wrap
    do_reset();
    wr(4'h6, 16'd3);
    wr(4'h4, 16'd0);
    wr(4'h2, 16'h0040);
    wr(4'h0, 16'h0001);
    tick_wait(7);  rd(4'h4, 16'd0, "R3 no advance before 8 cycles");
    tick_wait(1);  rd(4'h4, 16'd1, "R3 first advance");
    tick_wait(8);  rd(4'h4, 16'd2, "R3 second advance");
    tick_wait(8);  rd(4'h4, 16'd3, "R3 third advance");
    expect_val(16'(irq), 16'h0, "R6 irq low before match");
    tick_wait(8);  rd(4'h4, 16'd0, "R4 counter wraps on match");
    rd(4'h2, 16'h00C0, "R4 flag set on match");
    expect_val(16'(irq), 16'h1, "R6 irq high with flag and enable");

    // R5: write of 1 keeps flag, write of 0 clears it
    wr(4'h2, 16'h00C0); rd(4'h2, 16'h00C0, "R5 write one keeps flag");
    wr(4'h2, 16'h0080); rd(4'h2, 16'h0080, "R5 flag kept with enable off");
    expect_val(16'(irq), 16'h0, "R6 irq low with enable off");
    wr(4'h2, 16'h0000); rd(4'h2, 16'h0000, "R5 write zero clears flag");

    // R5: set beats clear on the same edge
    wr(4'h0, 16'h0000);
    wr(4'h4, 16'd3);
    wr(4'h2, 16'h0040);
    wr(4'h0, 16'h0001);
    tick_wait(7);
    wr(4'h2, 16'h0040);
    rd(4'h2, 16'h00C0, "R5 match wins over clear");
    rd(4'h4, 16'd0, "R4 wrap with coincident clear");

    // R8: counter load beats advance, compare change is immediate
    do_reset();
    wr(4'h0, 16'h0001);
    tick_wait(7);
    wr(4'h4, 16'h0100);
    rd(4'h4, 16'h0100, "R8 load replaces advance");
    wr(4'h6, 16'h0101);
    tick_wait(7);  rd(4'h4, 16'h0101, "R8 counting after load");
    tick_wait(8);  rd(4'h4, 16'h0000, "R8 new compare value used");
    rd(4'h2, 16'h0080, "R8 match on new compare");

    // R3, R7: /32, stop holds, restart gives full period
    do_reset();
    wr(4'h2, 16'h0001);
    wr(4'h0, 16'h0001);
    tick_wait(31); rd(4'h4, 16'd0, "R3 /32 before first advance");
    tick_wait(1);  rd(4'h4, 16'd1, "R3 /32 first advance");
    tick_wait(32); rd(4'h4, 16'd2, "R3 /32 second advance");
    tick_wait(10);
    wr(4'h0, 16'h0000);
    tick_wait(20); rd(4'h4, 16'd2, "R7 counter holds while stopped");
    wr(4'h0, 16'h0001);
    tick_wait(31); rd(4'h4, 16'd2, "R7 divider restarted");
    tick_wait(1);  rd(4'h4, 16'd3, "R7 advance after full period");

    // R2, R3, R9: channel 1 at /512, channel 0 stays idle
    do_reset();
    wr(4'h8, 16'h0003);
    wr(4'h0, 16'h0002);
    tick_wait(511); rd(4'hA, 16'd0, "R3 /512 before first advance");
    tick_wait(1);   rd(4'hA, 16'd1, "R3 /512 first advance");
    rd(4'h4, 16'd0, "R2 channel 0 not started");
    wr(4'h0, 16'h0003);
    rd(4'h0, 16'h0003, "R2 both run bits");
    wr(4'h0, 16'h0001);
    rd(4'h0, 16'h0001, "R2 clearing one bit leaves the other");

    finish_run();
  end
endmodule